// File: doc/BRIEF.md
# Async Serial Character Retimer

This block sits behind an FSK demodulator and watches the raw 1200 baud asynchronous bit stream it produces. It finds the start of each character and samples the data bits in the middle of each bit cell. It then gives the character to a host one bit at a time. The host clocks the bits out with a strobe, so its firmware can read characters with a simple polling loop and needs no UART. The system clock is 3.579545 MHz, which gives a bit period of about 2983 clocks. The bit period is a parameter.

The strobe level at the moment a character completes selects the mode. If the strobe is high, the block stays in bypass: the raw line is passed to the serial output and the interrupt is never raised. If the strobe is low, the block holds the character and drives its first bit on the serial output, and it pulls the active-low interrupt low. The host then gives eight strobe pulses. The first rising edge releases the interrupt. Each of the first seven falling edges moves the next bit onto the output. The eighth falling edge returns the output to the raw line.

Both the raw line and the strobe are asynchronous inputs. Each passes through a two-flop synchronizer. A strobe edge reaches the output three clocks after it happens, which is within 1 µs at the nominal clock. The host must collect all eight bits before the next character completes. A character that completes while the host is still collecting the previous one is dropped.

Top module: `serial_char_retimer`

## Requirements
- R1: While reset is asserted and right after it, irq_n is high and ser_out follows raw_in.
- R2: When strobe_in is high at the moment a character completes, ser_out keeps following raw_in with a delay of two clocks, and irq_n stays high.
- R3: A character starts on a 1-to-0 edge of raw_in. Its eight data bits are taken least significant bit first, with bit 0 sampled 1.5 bit periods after the start edge. If strobe_in is low when the eighth bit is sampled, irq_n goes low on the next clock and ser_out carries data bit 0.
- R4: irq_n goes high again within three clocks of the first rising edge of strobe_in, and it stays high until the next character is handed over.
- R5: Each of the first seven falling edges of strobe_in puts the next data bit (bit 1 to bit 7) on ser_out within three clocks. ser_out does not change at any other time during the handover.
- R6: Within three clocks of the eighth falling edge of strobe_in, ser_out follows raw_in again.
- R7: A continuous 0101... alternating stream, where each frame is a start bit, eight data bits and a stop bit, is read as characters of value 0x55.
- R8: A low pulse on raw_in that is gone by the middle of the start bit is ignored. irq_n stays high, and the next valid character is still received.
- R9: After the data bits, the block waits for a high (mark) level before it looks for a new start edge. If raw_in stays low after a character, no second character is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Raw asynchronous data from the demodulator, idle high |
| strobe_in | input | 1 | Host strobe. It selects the mode and clocks the held bits out |
| ser_out | output | 1 | Raw data in bypass, or the bit currently held during a handover |
| irq_n | output | 1 | Active-low flag that a character is waiting for the host |

## Verification
In bypass, ser_out must follow raw_in two clocks after it changes. The bench checks this on every clock against its own two-clock delayed copy of raw_in. A strobe edge takes effect on irq_n or ser_out three clocks later, so the bench samples on the falling clock edge four clocks after it moves the strobe. The interrupt is raised during the last data bit, about 8.5 bit periods plus four clocks after the start edge. For that reason the bench waits for irq_n with a bounded poll and does not assume an exact cycle. It then checks each bit against the character it sent.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [2:0] {
    RX_WAIT_MARK,
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  typedef enum logic {
    HO_BYPASS,
    HO_SERVE
  } ho_state_t;
endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/srt_rx_frame.sv
module srt_rx_frame
  import srt_pkg::*;
#(
  parameter int CLKS_PER_BIT = 2983,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line,
  output logic                 done,
  output logic [DATA_BITS-1:0] data
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int IW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

  rx_state_t      state;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_WAIT_MARK;
      cnt   <= '0;
      idx   <= '0;
      data  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RX_WAIT_MARK: begin
          cnt <= '0;
          if (line) state <= RX_IDLE;
        end
        RX_IDLE: begin
          cnt <= '0;
          if (!line) state <= RX_START;
        end
        RX_START: begin
          if (cnt == HALF_M1) begin
            cnt <= '0;
            idx <= '0;
            state <= line ? RX_WAIT_MARK : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == FULL_M1) begin
            cnt  <= '0;
            data <= {line, data[DATA_BITS-1:1]};
            if (idx == LAST_IDX) begin
              done  <= 1'b1;
              state <= RX_STOP;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == FULL_M1) begin
            cnt   <= '0;
            state <= RX_WAIT_MARK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_WAIT_MARK;
      endcase
    end
  end
endmodule

// File: rtl/srt_handoff.sv
module srt_handoff
  import srt_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 strobe_s,
  input  logic                 line,
  output logic                 irq_n,
  output logic                 ser_out,
  output logic                 serving
);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IW-1:0] LAST_FALL = IW'(DATA_BITS - 1);

  ho_state_t            st;
  logic                 strobe_d;
  logic [DATA_BITS-1:0] hold;
  logic [IW-1:0]        nfall;
  logic                 rise, fall;

  assign rise = strobe_s & ~strobe_d;
  assign fall = ~strobe_s & strobe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= HO_BYPASS;
      strobe_d <= 1'b0;
      hold     <= '0;
      nfall    <= '0;
      irq_n    <= 1'b1;
    end else begin
      strobe_d <= strobe_s;
      unique case (st)
        HO_BYPASS: begin
          if (done && !strobe_s) begin
            st    <= HO_SERVE;
            hold  <= data;
            nfall <= '0;
            irq_n <= 1'b0;
          end
        end
        HO_SERVE: begin
          if (rise) irq_n <= 1'b1;
          if (fall) begin
            if (nfall == LAST_FALL) begin
              st <= HO_BYPASS;
            end else begin
              hold  <= hold >> 1;
              nfall <= nfall + 1'b1;
            end
          end
        end
        default: st <= HO_BYPASS;
      endcase
    end
  end

  assign serving = (st == HO_SERVE);
  assign ser_out = serving ? hold[0] : line;
endmodule

// File: rtl/serial_char_retimer.sv
module serial_char_retimer #(
  parameter int CLKS_PER_BIT = 2983,
  parameter int DATA_BITS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic strobe_in,
  output logic ser_out,
  output logic irq_n
);
  logic [1:0]           sync_q;
  logic                 raw_s;
  logic                 strobe_s;
  logic                 char_done;
  logic [DATA_BITS-1:0] char_data;
  logic                 serving;

  srt_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({strobe_in, raw_in}),
    .q    (sync_q)
  );

  assign raw_s    = sync_q[0];
  assign strobe_s = sync_q[1];

  srt_rx_frame #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .line (raw_s),
    .done (char_done),
    .data (char_data)
  );

  srt_handoff #(.DATA_BITS(DATA_BITS)) u_ho (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (char_done),
    .data    (char_data),
    .strobe_s(strobe_s),
    .line    (raw_s),
    .irq_n   (irq_n),
    .ser_out (ser_out),
    .serving (serving)
  );
endmodule

// File: rtl/srt_checker.sv
module srt_checker (
  input logic clk,
  input logic rst_n,
  input logic irq_n,
  input logic ser_out,
  input logic strobe_s,
  input logic done,
  input logic serving
);
  AST_IRQ_ONLY_ON_LOW_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(done) && !$past(strobe_s))); // R3

  AST_IRQ_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && strobe_s && !$past(strobe_s)) |=> irq_n); // R4

  AST_IRQ_LOW_IMPLIES_SERVING: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> serving); // R4

  AST_HELD_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && $past(serving) && !($past(strobe_s, 2) && !$past(strobe_s)))
      |-> $stable(ser_out)); // R5

  AST_EXIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serving) |-> ($past(strobe_s, 2) && !$past(strobe_s))); // R6
endmodule

bind serial_char_retimer srt_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_n   (irq_n),
  .ser_out (ser_out),
  .strobe_s(strobe_s),
  .done    (char_done),
  .serving (serving)
);

// File: tb/sim_serial_char_retimer.sv
`timescale 1ns/1ps
module sim_serial_char_retimer;
  localparam int BIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_in = 1'b1;
  logic strobe_in = 1'b1;
  logic ser_out, irq_n;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic model_bypass = 1'b0;
  logic raw_d1 = 1'b1, raw_d2 = 1'b1;

  always #4 clk = ~clk;

  serial_char_retimer #(.CLKS_PER_BIT(BIT), .DATA_BITS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .strobe_in(strobe_in),
    .ser_out(ser_out), .irq_n(irq_n)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // two-clock latency reference for the bypass path
  always @(posedge clk) begin
    raw_d1 <= raw_in;
    raw_d2 <= raw_d1;
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    if (model_bypass && rst_n) begin
      check_eq("R2 bypass ser_out", 32'(ser_out), 32'(raw_d2));
      check_eq("R2 bypass irq_n", 32'(irq_n), 32'd1);
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic send_bit(input logic b);
    raw_in = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] v, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    send_bit(stop);
  endtask

  task automatic serve(input logic [7:0] exp, output logic [7:0] got);
    int t;
    t = 0;
    got = '0;
    while (irq_n !== 1'b0 && t < 40 * BIT) begin
      @(negedge clk);
      t++;
    end
    check_eq("R3 irq_n low after character", 32'(irq_n), 32'd0);
    check_eq("R3 first bit on ser_out", 32'(ser_out), 32'(exp[0]));
    for (int i = 0; i < 8; i++) begin
      got[i] = ser_out;
      strobe_in = 1'b1;
      repeat (4) @(negedge clk);
      check_eq("R4 irq_n released by strobe", 32'(irq_n), 32'd1);
      check_eq("R5 bit held while strobe high", 32'(ser_out), 32'(exp[i]));
      strobe_in = 1'b0;
      repeat (4) @(negedge clk);
      if (i < 7) check_eq("R5 next bit after fall", 32'(ser_out), 32'(exp[i+1]));
      else       check_eq("R6 ser_out back to raw", 32'(ser_out), 32'(raw_d2));
    end
  endtask

  initial begin
    logic [7:0] got, got2;
    // R1 reset state
    repeat (3) @(negedge clk);
    check_eq("R1 irq_n in reset", 32'(irq_n), 32'd1);
    check_eq("R1 ser_out in reset", 32'(ser_out), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1 irq_n after reset", 32'(irq_n), 32'd1);
    model_bypass = 1'b1;

    // R2 bypass with strobe held high
    send_char(8'hA3, 1'b1);
    send_char(8'h0F, 1'b1);
    repeat (2 * BIT) @(negedge clk);
    check_eq("R2 no irq in bypass", 32'(irq_n), 32'd1);

    // R3..R6 retimed handover
    model_bypass = 1'b0;
    strobe_in = 1'b0;
    repeat (4) @(negedge clk);
    send_char(8'h96, 1'b1);
    serve(8'h96, got);
    check_eq("R3 byte LSB first", 32'(got), 32'h96);
    model_bypass = 1'b1;
    repeat (BIT) @(negedge clk);
    model_bypass = 1'b0;
    send_char(8'h80, 1'b1);
    serve(8'h80, got);
    check_eq("R3 byte 0x80", 32'(got), 32'h80);
    model_bypass = 1'b1;
    repeat (BIT) @(negedge clk);

    // R8 glitch shorter than half a bit
    raw_in = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    raw_in = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    check_eq("R8 glitch ignored", 32'(irq_n), 32'd1);
    model_bypass = 1'b0;
    send_char(8'h3C, 1'b1);
    serve(8'h3C, got);
    check_eq("R8 rearmed after glitch", 32'(got), 32'h3C);
    model_bypass = 1'b1;
    repeat (BIT) @(negedge clk);

    // R9 line stays low after the data bits
    model_bypass = 1'b0;
    fork
      begin
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(logic'((8'hC5 >> i) & 1));
        raw_in = 1'b0;
        repeat (20 * BIT) @(negedge clk);
        raw_in = 1'b1;
      end
      begin
        serve(8'hC5, got);
        model_bypass = 1'b1;
      end
    join
    check_eq("R9 byte before break", 32'(got), 32'hC5);
    repeat (12 * BIT) @(negedge clk);
    check_eq("R9 no character from held low", 32'(irq_n), 32'd1);

    // R7 continuous alternating preamble
    model_bypass = 1'b0;
    fork
      begin
        for (int i = 0; i < 20; i++) send_bit(logic'(i % 2));
        raw_in = 1'b1;
      end
      begin
        serve(8'h55, got);
        serve(8'h55, got2);
      end
    join
    check_eq("R7 first preamble character", 32'(got), 32'h55);
    check_eq("R7 second preamble character", 32'(got2), 32'h55);
    model_bypass = 1'b1;
    repeat (4 * BIT) @(negedge clk);
    model_bypass = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule